// File: doc/BRIEF.md
# Parameter Page Reader and Validator

This block fetches the self-describing parameter page from an attached flash device and turns it into a small set of geometry and timing registers. A `start` pulse makes it send one command byte (ECh) and then one address byte (00h) over a request port. It then takes the 256-byte page one byte per `rd_valid` strobe from a lower-level read-cycle engine.

Each 256-byte copy is checked as it streams in. The first four bytes must form the signature, and a 16-bit CRC over bytes 0 to 253 must match the value stored in bytes 254 and 255. A copy that fails either test is dropped, and the block goes on with the next copy from the same stream. The device stays in parameter-page mode, so no command is sent again. At most three copies are tried. The registers are loaded only from a copy that passes both tests. A one-cycle `done` pulse reports which copy was used, or reports the error if every copy failed.

Top module: `param_page_reader`

## Requirements
- R1: On an accepted `start`, `req_valid` rises the next cycle with `req_byte`=ECh and `req_is_addr`=0. After `req_ready` it presents `req_byte`=00h with `req_is_addr`=1. Each request is held unchanged until `req_ready` is high.
- R2: Page bytes are taken only while `stream_en` is high, which is from the cycle after the address handshake until the result. `rd_valid` at any other time is ignored, and so is a `start` while `busy` is high.
- R3: A copy is rejected unless its bytes 0,1,2,3 are 4Fh,4Eh,46h,49h.
- R4: A copy is rejected unless a CRC-16 over its bytes 0..253 equals {byte255, byte254} (byte 254 is the low byte). The CRC uses polynomial 8005h and seed 4F4Eh, is fed MSB first, and has no final inversion.
- R5: After a rejected copy 0 the next 256 bytes are judged as copy 1, then copy 2, with no new command issued.
- R6: When a copy passes, `done` is high in the cycle after its byte 255 was taken, `done_copy` gives its index (0, 1 or 2), and `err` is low.
- R7: If copies 0, 1 and 2 all fail, `done` pulses with `err`=1 and `done_copy`=2, and the field outputs keep their earlier values (zero after reset). `err` stays set until the next accepted `start` clears it.
- R8: Field map (little-endian): `page_bytes` from bytes 80..83, `pages_per_blk` from 92..95, `col_cycles`=byte101[7:4], `row_cycles`=byte101[3:0], `t_prog` from 133..134, `t_erase` from 135..136, `t_read` from 137..138.
- R9: After reset all outputs are zero, except that no request is pending and the block is idle.
- R10: `done` lasts exactly one cycle per read, and the field outputs change only in a cycle where `done`=1 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a parameter page read (ignored while busy) |
| req_valid | output | 1 | Command/address byte pending |
| req_is_addr | output | 1 | 0 = command byte, 1 = address byte |
| req_byte | output | 8 | Byte to issue |
| req_ready | input | 1 | Request accepted this cycle |
| rd_valid | input | 1 | Page byte strobe |
| rd_byte | input | 8 | Page byte |
| stream_en | output | 1 | Block is accepting page bytes |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| done_copy | output | CPY_W (2) | Index of the copy judged last |
| err | output | 1 | All copies failed |
| page_bytes | output | 32 | Data bytes per page |
| pages_per_blk | output | 32 | Pages per block |
| col_cycles | output | 4 | Column address cycles |
| row_cycles | output | 4 | Row address cycles |
| t_prog | output | 16 | Max program time, µs |
| t_erase | output | 16 | Max erase time, µs |
| t_read | output | 16 | Max read time, µs |

## Verification
The read is run with a clean copy 0, with a CRC-corrupted copy 0 followed by a good copy 1, and with copies 0 and 1 carrying a bad signature but a matching CRC. These runs separate the signature test from the CRC test and prove the copy index advances. Two all-failing runs, one straight from reset and one after a successful read, show that nothing is committed on error. Byte gaps, request stalls, stray strobes before a read and a `start` pulse in mid-stream check that only handshaked bytes count and that the idle-only start rule holds.

// File: rtl/pp_pkg.sv
// Shared constants and the CRC byte step for the parameter page reader.
// Assumes the page layout is fixed: signature first, CRC in the last two bytes.
package pp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_ADR  = 2'd2,
        ST_RUN  = 2'd3
    } pp_state_e;

    localparam logic [7:0]  OP_PARAM_PAGE = 8'hEC;
    localparam logic [7:0]  OP_ADDR_BYTE  = 8'h00;
    localparam logic [15:0] CRC_POLY      = 16'h8005;
    localparam logic [15:0] CRC_SEED      = 16'h4F4E;
    localparam logic [31:0] SIG_WORD      = 32'h49464E4F;  // byte 0 in bits 7:0
    localparam int          SIG_LEN       = 4;

    localparam int OFS_PAGE_BYTES = 80;
    localparam int OFS_PAGES_BLK  = 92;
    localparam int OFS_ADDR_CYC   = 101;
    localparam int OFS_T_PROG     = 133;
    localparam int OFS_T_ERASE    = 135;
    localparam int OFS_T_READ     = 137;

    // Advance the CRC by one byte, most significant bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/pp_crc_acc.sv
// Running CRC-16 over the accepted bytes of one copy.
// Assumes the caller gates en to the covered byte range and pulses clr between copies.
module pp_crc_acc
    import pp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Seed on reset or clear, otherwise fold in one byte per enable.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= CRC_SEED;
        else if (clr) crc <= CRC_SEED;
        else if (en)  crc <= crc_step(crc, din);
    end

endmodule

// File: rtl/pp_sig_chk.sv
// Tracks whether the leading signature bytes of the current copy matched.
// Assumes idx counts bytes within the copy and clr arrives before byte 0.
module pp_sig_chk
    import pp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic             ok
);

    logic [7:0] want;
    logic       in_sig;

    // Select the expected signature byte for this position.
    always_comb begin
        want   = SIG_WORD[8*idx[1:0] +: 8];
        in_sig = take && (idx < IDX_W'(SIG_LEN));
    end

    // Clear to passing, then drop on any mismatching signature byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      ok <= 1'b1;
        else if (clr)    ok <= 1'b1;
        else if (in_sig) ok <= ok && (din == want);
    end

endmodule

// File: rtl/pp_field_grab.sv
// Shadow register for one little-endian field of NB bytes starting at BASE.
// Assumes every byte of the field is rewritten by each copy before it is committed.
module pp_field_grab #(
    parameter int IDX_W = 8,
    parameter int BASE  = 0,
    parameter int NB    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [8*NB-1:0]  val
);

    for (genvar k = 0; k < NB; k++) begin : g_lane
        // Capture byte k of the field when its position goes by.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val[8*k +: 8] <= 8'h00;
            else if (take && (idx == IDX_W'(BASE + k)))
                val[8*k +: 8] <= din;
        end
    end

endmodule

// File: rtl/param_page_reader.sv
// Parameter page reader: issues the page command and address, streams copies,
// validates each by signature and CRC, and commits fields from the first good copy.
// Assumes the device keeps streaming redundant copies back to back after the address.
module param_page_reader
    import pp_pkg::*;
#(
    parameter  int PAGE_LEN   = 256,
    parameter  int NUM_COPIES = 3,
    localparam int IDX_W      = $clog2(PAGE_LEN),
    localparam int CPY_W      = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             req_valid,
    output logic             req_is_addr,
    output logic [7:0]       req_byte,
    input  logic             req_ready,
    input  logic             rd_valid,
    input  logic [7:0]       rd_byte,
    output logic             stream_en,
    output logic             busy,
    output logic             done,
    output logic [CPY_W-1:0] done_copy,
    output logic             err,
    output logic [31:0]      page_bytes,
    output logic [31:0]      pages_per_blk,
    output logic [3:0]       col_cycles,
    output logic [3:0]       row_cycles,
    output logic [15:0]      t_prog,
    output logic [15:0]      t_erase,
    output logic [15:0]      t_read
);

    localparam int CRC_END = PAGE_LEN - 2;

    pp_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [CPY_W-1:0] copy;
    logic             take;
    logic             last;
    logic             restart;
    logic             crc_en;
    logic [15:0]      crc_q;
    logic             sig_ok;
    logic             pass;
    logic             final_copy;

    logic [31:0] sh_page_bytes;
    logic [31:0] sh_pages_blk;
    logic [7:0]  sh_cyc;
    logic [15:0] sh_prog;
    logic [15:0] sh_erase;
    logic [15:0] sh_read;
    logic [7:0]  sh_crc_lo;

    // Decode request port, stream window and per-byte strobes from the state.
    always_comb begin
        req_valid   = (state == ST_CMD) || (state == ST_ADR);
        req_is_addr = (state == ST_ADR);
        req_byte    = (state == ST_ADR) ? OP_ADDR_BYTE : OP_PARAM_PAGE;
        stream_en   = (state == ST_RUN);
        busy        = (state != ST_IDLE);
        take        = stream_en && rd_valid;
        last        = (idx == IDX_W'(PAGE_LEN - 1));
        restart     = ((state == ST_ADR) && req_ready) || (take && last);
        crc_en      = take && (idx < IDX_W'(CRC_END));
        final_copy  = (copy == CPY_W'(NUM_COPIES - 1));
        pass        = sig_ok && ({rd_byte, sh_crc_lo} == crc_q);
    end

    pp_crc_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .en    (crc_en),
        .din   (rd_byte),
        .crc   (crc_q)
    );

    pp_sig_chk #(.IDX_W(IDX_W)) u_sig (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .take  (take),
        .idx   (idx),
        .din   (rd_byte),
        .ok    (sig_ok)
    );

    pp_field_grab #(.IDX_W(IDX_W), .BASE(OFS_PAGE_BYTES), .NB(4)) u_f_pb (
        .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(rd_byte), .val(sh_page_bytes)
    );
    pp_field_grab #(.IDX_W(IDX_W), .BASE(OFS_PAGES_BLK), .NB(4)) u_f_ppb (
        .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(rd_byte), .val(sh_pages_blk)
    );
    pp_field_grab #(.IDX_W(IDX_W), .BASE(OFS_ADDR_CYC), .NB(1)) u_f_cyc (
        .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(rd_byte), .val(sh_cyc)
    );
    pp_field_grab #(.IDX_W(IDX_W), .BASE(OFS_T_PROG), .NB(2)) u_f_tp (
        .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(rd_byte), .val(sh_prog)
    );
    pp_field_grab #(.IDX_W(IDX_W), .BASE(OFS_T_ERASE), .NB(2)) u_f_te (
        .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(rd_byte), .val(sh_erase)
    );
    pp_field_grab #(.IDX_W(IDX_W), .BASE(OFS_T_READ), .NB(2)) u_f_tr (
        .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(rd_byte), .val(sh_read)
    );
    pp_field_grab #(.IDX_W(IDX_W), .BASE(CRC_END), .NB(1)) u_f_crc (
        .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .din(rd_byte), .val(sh_crc_lo)
    );

    // Sequence command, address and the stream of copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (start)     state <= ST_CMD;
                ST_CMD:  if (req_ready) state <= ST_ADR;
                ST_ADR:  if (req_ready) state <= ST_RUN;
                ST_RUN:  if (take && last && (pass || final_copy)) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Count bytes within a copy and which copy is being judged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            copy <= '0;
        end else if ((state == ST_ADR) && req_ready) begin
            idx  <= '0;
            copy <= '0;
        end else if (take) begin
            idx <= last ? '0 : idx + 1'b1;
            if (last && !pass && !final_copy) copy <= copy + 1'b1;
        end
    end

    // Report completion, copy index and the all-failed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            done_copy <= '0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            if ((state == ST_IDLE) && start) err <= 1'b0;
            if (take && last && (pass || final_copy)) begin
                done      <= 1'b1;
                done_copy <= copy;
                err       <= !pass;
            end
        end
    end

    // Commit shadow fields only from a copy that passed both checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_bytes    <= '0;
            pages_per_blk <= '0;
            col_cycles    <= '0;
            row_cycles    <= '0;
            t_prog        <= '0;
            t_erase       <= '0;
            t_read        <= '0;
        end else if (take && last && pass) begin
            page_bytes    <= sh_page_bytes;
            pages_per_blk <= sh_pages_blk;
            col_cycles    <= sh_cyc[7:4];
            row_cycles    <= sh_cyc[3:0];
            t_prog        <= sh_prog;
            t_erase       <= sh_erase;
            t_read        <= sh_read;
        end
    end

endmodule

// File: rtl/param_page_reader_chk.sv
// Property checker for param_page_reader, attached by bind below.
module param_page_reader_chk #(
    parameter int NUM_COPIES = 3,
    parameter int CPY_W      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_valid,
    input logic             req_is_addr,
    input logic [7:0]       req_byte,
    input logic             req_ready,
    input logic             stream_en,
    input logic             busy,
    input logic             done,
    input logic [CPY_W-1:0] done_copy,
    input logic             err,
    input logic [127:0]     fields
);

    // R1: a pending request holds its byte and kind until accepted
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_byte) && $stable(req_is_addr));

    // R2: streaming only happens inside a busy read with no request pending
    a_r2_stream_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stream_en |-> busy && !req_valid);

    // R7: a rising error flag comes with done on the last copy
    a_r7_err_last_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done && (done_copy == CPY_W'(NUM_COPIES - 1)));

    // R7: the error flag is cleared only by an accepted start
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(start) && !$past(busy));

    // R6: the reported copy index is within range
    a_r6_copy_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_copy <= CPY_W'(NUM_COPIES - 1));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: fields move only together with a passing done
    a_r10_fields_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fields) |-> done && !err);

endmodule

bind param_page_reader param_page_reader_chk #(
    .NUM_COPIES (NUM_COPIES),
    .CPY_W      (CPY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_valid   (req_valid),
    .req_is_addr (req_is_addr),
    .req_byte    (req_byte),
    .req_ready   (req_ready),
    .stream_en   (stream_en),
    .busy        (busy),
    .done        (done),
    .done_copy   (done_copy),
    .err         (err),
    .fields      ({page_bytes, pages_per_blk, col_cycles, row_cycles, t_prog, t_erase, t_read})
);

// File: tb/param_page_reader_test.sv
`timescale 1ns/1ps
module param_page_reader_test;

    typedef logic [7:0] bq_t [$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_ready = 1'b1;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_byte = 8'h00;
    logic        req_valid, req_is_addr, stream_en, busy, done, err;
    logic [7:0]  req_byte;
    logic [1:0]  done_copy;
    logic [31:0] page_bytes, pages_per_blk;
    logic [3:0]  col_cycles, row_cycles;
    logic [15:0] t_prog, t_erase, t_read;

    int vectors = 0;
    int misses  = 0;
    bit stall_mode = 1'b0;

    always #2.5 clk = ~clk;

    param_page_reader uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_is_addr(req_is_addr), .req_byte(req_byte), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .stream_en(stream_en), .busy(busy),
        .done(done), .done_copy(done_copy), .err(err),
        .page_bytes(page_bytes), .pages_per_blk(pages_per_blk),
        .col_cycles(col_cycles), .row_cycles(row_cycles),
        .t_prog(t_prog), .t_erase(t_erase), .t_read(t_read)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // CRC-16, seed 4F4E, poly 8005, MSB first, over the first 254 bytes.
    function automatic logic [15:0] ref_crc(input bq_t q);
        int c = 'h4F4E;
        for (int i = 0; i < 254; i++) begin
            for (int b = 7; b >= 0; b--) begin
                int top = ((c >> 15) & 1) ^ ((q[i] >> b) & 1);
                c = (c << 1) & 'hFFFF;
                if (top != 0) c = c ^ 'h8005;
            end
        end
        return c[15:0];
    endfunction

    // ---------------- reference model ----------------
    int          m_phase = 0;
    int          m_copy  = 0;
    bq_t         m_q;
    logic        e_done = 0, e_err = 0;
    logic [1:0]  e_copy = 0;
    logic [31:0] e_pb = 0, e_ppb = 0;
    logic [7:0]  e_cyc = 0;
    logic [15:0] e_tp = 0, e_te = 0, e_tr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_copy = 0; m_q.delete();
            e_done = 0; e_err = 0; e_copy = 0;
            e_pb = 0; e_ppb = 0; e_cyc = 0; e_tp = 0; e_te = 0; e_tr = 0;
        end else begin
            e_done = 0;
            case (m_phase)
                0: if (start) begin m_phase = 1; e_err = 0; end
                1: if (req_ready) m_phase = 2;
                2: if (req_ready) begin m_phase = 3; m_copy = 0; m_q.delete(); end
                default: if (rd_valid) begin
                    m_q.push_back(rd_byte);
                    if (m_q.size() == 256) begin
                        logic [15:0] stored;
                        bit ok;
                        stored = {m_q[255], m_q[254]};
                        ok = (m_q[0] == 8'h4F) && (m_q[1] == 8'h4E) && (m_q[2] == 8'h46) &&
                             (m_q[3] == 8'h49) && (ref_crc(m_q) == stored);
                        if (ok) begin
                            e_pb  = {m_q[83], m_q[82], m_q[81], m_q[80]};
                            e_ppb = {m_q[95], m_q[94], m_q[93], m_q[92]};
                            e_cyc = m_q[101];
                            e_tp  = {m_q[134], m_q[133]};
                            e_te  = {m_q[136], m_q[135]};
                            e_tr  = {m_q[138], m_q[137]};
                            e_done = 1; e_copy = m_copy[1:0]; m_phase = 0;
                        end else if (m_copy == 2) begin
                            e_done = 1; e_err = 1; e_copy = 2; m_phase = 0;
                        end else begin
                            m_copy++;
                        end
                        m_q.delete();
                    end
                end
            endcase
        end
    end

    // Compare every output against the model, away from the clock edge.
    always @(negedge clk) begin
        check("R1 req_valid", req_valid, (m_phase == 1) || (m_phase == 2));
        if (req_valid) begin
            check("R1 req_byte", req_byte, (m_phase == 2) ? 8'h00 : 8'hEC);
            check("R1 req_is_addr", req_is_addr, m_phase == 2);
        end
        check("R2 stream_en", stream_en, m_phase == 3);
        check("R2 busy", busy, m_phase != 0);
        check("R6 done", done, e_done);
        if (e_done) check("R6 done_copy", done_copy, e_copy);
        check("R7 err", err, e_err);
        check("R8 page_bytes", page_bytes, e_pb);
        check("R8 pages_per_blk", pages_per_blk, e_ppb);
        check("R8 col_cycles", col_cycles, e_cyc[7:4]);
        check("R8 row_cycles", row_cycles, e_cyc[3:0]);
        check("R8 t_prog", t_prog, e_tp);
        check("R8 t_erase", t_erase, e_te);
        check("R8 t_read", t_read, e_tr);
    end

    // Port-level observation of done pulses.
    int         done_cnt = 0;
    logic [1:0] seen_copy = 0;
    logic       seen_err = 0;
    always @(negedge clk) begin
        if (done) begin done_cnt++; seen_copy = done_copy; seen_err = err; end
    end

    // Request-port back-pressure pattern.
    always @(negedge clk) req_ready = stall_mode ? ~req_ready : 1'b1;

    // ---------------- stimulus ----------------
    logic [7:0]  img [0:255];
    logic [31:0] tv_pb, tv_ppb;
    logic [7:0]  tv_cyc;
    logic [15:0] tv_tp, tv_te, tv_tr;

    // mode 0 = good copy, 1 = CRC corrupted, 2 = signature corrupted with matching CRC
    task automatic build(input int mode, input int salt);
        bq_t q;
        logic [15:0] c;
        for (int i = 0; i < 256; i++) img[i] = 8'((i * 7 + salt * 13 + 5) & 255);
        img[0] = 8'h4F; img[1] = 8'h4E; img[2] = 8'h46; img[3] = 8'h49;
        for (int k = 0; k < 4; k++) img[80 + k] = tv_pb[8*k +: 8];
        for (int k = 0; k < 4; k++) img[92 + k] = tv_ppb[8*k +: 8];
        img[101] = tv_cyc;
        img[133] = tv_tp[7:0]; img[134] = tv_tp[15:8];
        img[135] = tv_te[7:0]; img[136] = tv_te[15:8];
        img[137] = tv_tr[7:0]; img[138] = tv_tr[15:8];
        if (mode == 2) img[2] = 8'h47;
        for (int i = 0; i < 256; i++) q.push_back(img[i]);
        c = ref_crc(q);
        img[254] = c[7:0]; img[255] = c[15:8];
        if (mode == 1) img[254] = img[254] ^ 8'h10;
    endtask

    task automatic do_read(input int modes [3], input int n, input bit gaps, input bit poke);
        done_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!stream_en) @(negedge clk);
        for (int c = 0; c < n; c++) begin
            build(modes[c], c + n);
            for (int i = 0; i < 256; i++) begin
                if (gaps && (i % 5 == 3)) begin rd_valid = 1'b0; @(negedge clk); end
                if (poke && c == 0 && i == 100) start = 1'b1;
                rd_valid = 1'b1; rd_byte = img[i];
                @(negedge clk);
                start = 1'b0;
            end
        end
        rd_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_fields(input string tag);
        check({tag, " page_bytes"}, page_bytes, tv_pb);
        check({tag, " pages_per_blk"}, pages_per_blk, tv_ppb);
        check({tag, " col_cycles"}, col_cycles, tv_cyc[7:4]);
        check({tag, " row_cycles"}, row_cycles, tv_cyc[3:0]);
        check({tag, " t_prog"}, t_prog, tv_tp);
        check({tag, " t_erase"}, t_erase, tv_te);
        check({tag, " t_read"}, t_read, tv_tr);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 done", done, 0);
        check("R9 err", err, 0);
        check("R9 req_valid", req_valid, 0);
        check("R9 busy", busy, 0);
        check("R9 page_bytes", page_bytes, 0);

        // R7: every copy bad straight from reset, fields stay zero
        tv_pb = 32'h0000_0800; tv_ppb = 32'h40; tv_cyc = 8'h23;
        tv_tp = 16'h02BC; tv_te = 16'h2710; tv_tr = 16'h0019;
        do_read('{1, 2, 1}, 3, 1'b0, 1'b0);
        check("R7 err", seen_err, 1);
        check("R7 copy", seen_copy, 2);
        check("R10 one done", done_cnt, 1);
        check("R7 fields kept", {page_bytes, t_prog}, 48'h0);
        repeat (10) @(negedge clk);
        check("R7 err held", err, 1);

        // R2: stray strobes while idle are ignored
        rd_valid = 1'b1; rd_byte = 8'hA5;
        repeat (6) @(negedge clk);
        rd_valid = 1'b0;
        check("R2 stray busy", busy, 0);
        check("R2 stray done", done_cnt, 1);

        // R6 R1: good copy 0 with request stalls
        stall_mode = 1'b1;
        do_read('{0, 0, 0}, 1, 1'b0, 1'b0);
        stall_mode = 1'b0;
        check("R6 err", seen_err, 0);
        check("R7 err cleared", err, 0);
        check("R6 copy", seen_copy, 0);
        check_fields("R8");

        // R4 R5: bad CRC on copy 0, good copy 1
        tv_pb = 32'h1234_5678; tv_ppb = 32'h0102_0304; tv_cyc = 8'h35;
        tv_tp = 16'hBEEF; tv_te = 16'h1357; tv_tr = 16'h8001;
        do_read('{1, 0, 0}, 2, 1'b0, 1'b0);
        check("R4 R5 copy", seen_copy, 1);
        check("R4 err", seen_err, 0);
        check_fields("R4");

        // R3 R5 R2: bad signature twice, good copy 2, gaps, start mid-stream
        tv_pb = 32'hCAFE_0200; tv_ppb = 32'h80; tv_cyc = 8'h14;
        tv_tp = 16'h0400; tv_te = 16'h0F00; tv_tr = 16'h0033;
        do_read('{2, 2, 0}, 3, 1'b1, 1'b1);
        check("R3 R5 copy", seen_copy, 2);
        check("R3 err", seen_err, 0);
        check("R2 start ignored", busy, 0);
        check("R10 one done", done_cnt, 1);
        check_fields("R3");

        // R7: all bad after a pass, previous fields kept
        do_read('{2, 1, 2}, 3, 1'b0, 1'b0);
        check("R7 err", seen_err, 1);
        check_fields("R7");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule